// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when a memory controller sends refresh commands to its SDRAM. When the refresh enable input goes high, the block requests one refresh at once. After that, a free-running interval counter requests one refresh every `interval` cycles. A request that comes while a read or write is in progress is kept pending. The block issues it in the first cycle the access is over. At most one request waits at a time. Each auto-refresh command is followed by `rec_width` deselect cycles. A `busy` output tells the access arbiter not to start new accesses during that time. A single command output serves every SDRAM channel, so one refresh covers all of them.

The block also handles low power. The controller asks for low power with `lp_req`, and `lp_deep` selects self-refresh or deep power-down. The block drives the entry command and lowers the clock enable. The interval counter is frozen while the memory sleeps. When `lp_req` falls, the block raises clock enable for one deselect cycle and then sends the matching exit command. It then sends `rec_width` deselects and a forced recovery auto-refresh. The interval counter restarts from that recovery refresh.

Top module: `sdram_refresh_sched`

## Requirements
- R1: Within two cycles of `refresh_en` rising, an auto-refresh command (cmd code 1) appears on `cmd`. It does not wait for an interval to expire.
- R2: With no access and no low-power request, consecutive auto-refresh commands (code 1) are exactly `interval` cycles apart.
- R3: Each auto-refresh command (code 1) is followed by `rec_width` deselect cycles (code 0). `busy` is high from the refresh cycle through those deselects and low in the cycle after them.
- R4: While `access_active` is high and `busy` is low, no auto-refresh is issued. A held request is issued in the first cycle after `access_active` falls.
- R5: At most one request is held pending. After an access that spans several interval expiries, exactly one auto-refresh follows. The interval counter keeps running during the access.
- R6: While `refresh_en` is low, no new auto-refresh is issued and any pending request is cancelled. A refresh already issued still completes its `rec_width` deselects with `busy` high.
- R7: When `lp_req` is high, no request is pending and no access is active, the block issues self-refresh entry (code 2) or, when `lp_deep` is high, deep power-down entry (code 4), with `cke` low. While `cke` is low, no auto-refresh is issued and the interval counter is frozen.
- R8: When `lp_req` falls, the block drives one deselect with `cke` high, then the exit command: code 3 after self-refresh, code 5 after deep power-down. Then come `rec_width` deselects (code 0) and an auto-refresh (code 1). The next regular refresh follows `interval` cycles after that recovery refresh.
- R9: When a pending refresh and a low-power request are both present, the refresh is issued first. Low-power entry follows once its recovery has ended.
- R10: After reset, `cmd` is deselect (code 0), `cke` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_en | input | 1 | Refresh enable (software control bit) |
| interval | input | CNT_W | Refresh interval in cycles |
| rec_width | input | REC_W | Deselect cycles after each auto-refresh and after a low-power exit |
| access_active | input | 1 | A read or write access is in progress |
| lp_req | input | 1 | Request to enter and stay in low power |
| lp_deep | input | 1 | Low-power kind: 1 = deep power-down, 0 = self-refresh |
| cmd | output | 3 | Command: 0 deselect, 1 auto-refresh, 2 self-refresh entry, 3 self-refresh exit, 4 deep power-down entry, 5 deep power-down exit |
| cke | output | 1 | SDRAM clock enable |
| busy | output | 1 | Arbiter must not start a new access |

## Verification
A pending refresh and a low-power request can both be ready in the same idle cycle. The bench provokes this by holding an access across an interval expiry. It then drops `access_active` and raises `lp_req` on the same edge. It requires that an auto-refresh come first, with `cke` still high, and that self-refresh entry appear exactly four cycles later. An interval expiry that lands on the same cycle as an ongoing access is also provoked. The bench judges it by requiring a single refresh in the cycle after the access ends and none in the ten cycles after that.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CNT_W = 12,
  parameter int REC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_en,
  input  logic [CNT_W-1:0] interval,
  input  logic [REC_W-1:0] rec_width,
  input  logic             access_active,
  input  logic             lp_req,
  input  logic             lp_deep,
  output logic [2:0]       cmd,
  output logic             cke,
  output logic             busy
);
  localparam logic [2:0] C_DSL = 3'd0, C_REF = 3'd1, C_SRE = 3'd2,
                         C_SRX = 3'd3, C_PDE = 3'd4, C_PDX = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_RECOV, S_LP, S_WAKE, S_GAP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [REC_W-1:0] wcnt;
  logic             pend, en_q, deep;

  wire             frozen   = (st == S_LP) || (st == S_WAKE) || (st == S_GAP);
  wire [CNT_W:0]   cnt_nx   = {1'b0, cnt} + 1'b1;
  wire             expire   = refresh_en && en_q && !frozen && (cnt_nx >= {1'b0, interval});
  wire             fire     = (st == S_IDLE) && pend && refresh_en && !access_active;
  wire             wake_ref = (st == S_GAP) && (wcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= refresh_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            cnt <= '0;
    else if (!refresh_en || !en_q || expire) cnt <= '0;
    else if (wake_ref)                     cnt <= CNT_W'(1);
    else if (!frozen)                      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   pend <= 1'b0;
    else if (!refresh_en)         pend <= 1'b0;
    else if (expire || !en_q)     pend <= 1'b1;
    else if (fire || wake_ref)    pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cmd  <= C_DSL;
      cke  <= 1'b1;
      busy <= 1'b0;
      wcnt <= '0;
      deep <= 1'b0;
    end else begin
      cmd <= C_DSL;
      case (st)
        S_IDLE: begin
          if (fire) begin
            cmd  <= C_REF;
            busy <= 1'b1;
            wcnt <= rec_width;
            st   <= S_RECOV;
          end else if (lp_req && !pend && !access_active) begin
            cmd  <= lp_deep ? C_PDE : C_SRE;
            deep <= lp_deep;
            cke  <= 1'b0;
            busy <= 1'b1;
            st   <= S_LP;
          end
        end
        S_RECOV: begin
          if (wcnt == '0) begin
            busy <= 1'b0;
            st   <= S_IDLE;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        S_LP: begin
          if (!lp_req) begin
            cke <= 1'b1;
            st  <= S_WAKE;
          end
        end
        S_WAKE: begin
          cmd  <= deep ? C_PDX : C_SRX;
          wcnt <= rec_width;
          st   <= S_GAP;
        end
        S_GAP: begin
          if (wcnt == '0) begin
            cmd  <= C_REF;
            wcnt <= rec_width;
            st   <= S_RECOV;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       refresh_en,
  input logic       access_active,
  input logic [2:0] cmd,
  input logic       cke,
  input logic       busy
);
  p_ref_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd1 |-> busy);

  p_ref_then_dsl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd1 |=> cmd == 3'd0);

  p_hold_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (access_active && !busy) |=> cmd != 3'd1);

  p_no_ref_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_en && !busy) |=> cmd != 3'd1);

  p_no_ref_cke_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd != 3'd1);

  p_entry_cke_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2 || cmd == 3'd4) |-> !cke);

  p_exit_cke_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd3 || cmd == 3'd5) |-> (cke && $past(cke)));
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en),
  .access_active(access_active), .cmd(cmd), .cke(cke), .busy(busy)
);

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refresh_en = 1'b0;
  logic [11:0] interval = 12'd20;
  logic [3:0]  rec_width = 4'd2;
  logic        access_active = 1'b0;
  logic        lp_req = 1'b0;
  logic        lp_deep = 1'b0;
  logic [2:0]  cmd;
  logic        cke;
  logic        busy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdram_refresh_sched u_sdram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en), .interval(interval),
    .rec_width(rec_width), .access_active(access_active), .lp_req(lp_req),
    .lp_deep(lp_deep), .cmd(cmd), .cke(cke), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_cmd(input logic [2:0] code, input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      step();
      if (cmd == code) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic count_refs(input int len, output int refs, output int cke_hi);
    refs = 0;
    cke_hi = 0;
    for (int i = 0; i < len; i++) begin
      step();
      if (cmd == 3'd1) refs++;
      if (cke) cke_hi++;
    end
  endtask

  task automatic t_reset();
    chk(cmd == 3'd0, "R10 cmd", cmd, 0);
    chk(cke == 1'b1, "R10 cke", cke, 1);
    chk(busy == 1'b0, "R10 busy", busy, 0);
  endtask

  task automatic t_enable();
    int n;
    interval = 12'd20;
    rec_width = 4'd2;
    refresh_en = 1'b1;
    wait_cmd(3'd1, 10, n);
    chk(n == 2, "R1 first refresh delay", n, 2);
    chk(busy == 1'b1, "R3 busy on refresh", busy, 1);
    step();
    chk(cmd == 3'd0 && busy, "R3 deselect 1", cmd, 0);
    step();
    chk(cmd == 3'd0 && busy, "R3 deselect 2", cmd, 0);
    step();
    chk(busy == 1'b0, "R3 busy falls", busy, 0);
  endtask

  task automatic t_period(input int iv);
    int n;
    interval = 12'(iv);
    wait_cmd(3'd1, 100, n);
    wait_cmd(3'd1, 100, n);
    chk(n == iv, "R2 refresh spacing", n, iv);
  endtask

  task automatic t_access();
    int n, refs, hi;
    interval = 12'd20;
    wait_cmd(3'd1, 100, n);
    access_active = 1'b1;
    count_refs(60, refs, hi);
    chk(refs == 0, "R4 no refresh during access", refs, 0);
    access_active = 1'b0;
    wait_cmd(3'd1, 5, n);
    chk(n == 1, "R4 refresh right after access", n, 1);
    count_refs(10, refs, hi);
    chk(refs == 0, "R5 single pending refresh", refs, 0);
  endtask

  task automatic t_disable();
    int n, refs, hi;
    wait_cmd(3'd1, 100, n);
    refresh_en = 1'b0;
    step();
    step();
    chk(busy == 1'b1, "R6 recovery continues", busy, 1);
    step();
    chk(busy == 1'b0, "R6 recovery ends", busy, 0);
    count_refs(60, refs, hi);
    chk(refs == 0, "R6 no refresh when disabled", refs, 0);
    refresh_en = 1'b1;
    wait_cmd(3'd1, 100, n);
    access_active = 1'b1;
    repeat (25) step();
    refresh_en = 1'b0;
    access_active = 1'b0;
    count_refs(40, refs, hi);
    chk(refs == 0, "R6 pending request cancelled", refs, 0);
  endtask

  task automatic t_lowpower(input bit dp);
    int n, refs, hi;
    logic [2:0] ent, ext;
    ent = dp ? 3'd4 : 3'd2;
    ext = dp ? 3'd5 : 3'd3;
    interval = 12'd20;
    rec_width = 4'd2;
    refresh_en = 1'b1;
    wait_cmd(3'd1, 100, n);
    repeat (4) step();
    lp_req = 1'b1;
    lp_deep = dp;
    step();
    chk(cmd == ent, "R7 entry command", cmd, ent);
    chk(cke == 1'b0, "R7 cke low", cke, 0);
    count_refs(60, refs, hi);
    chk(refs == 0, "R7 no refresh in low power", refs, 0);
    chk(hi == 0, "R7 cke held low", hi, 0);
    lp_req = 1'b0;
    step();
    chk(cke == 1'b1 && cmd == 3'd0, "R8 cke up with deselect", cmd, 0);
    step();
    chk(cmd == ext, "R8 exit command", cmd, ext);
    step();
    chk(cmd == 3'd0, "R8 gap deselect 1", cmd, 0);
    step();
    chk(cmd == 3'd0, "R8 gap deselect 2", cmd, 0);
    step();
    chk(cmd == 3'd1, "R8 recovery refresh", cmd, 1);
    wait_cmd(3'd1, 100, n);
    chk(n == 20, "R8 counter restarted", n, 20);
  endtask

  task automatic t_race();
    int n;
    interval = 12'd20;
    wait_cmd(3'd1, 100, n);
    repeat (4) step();
    access_active = 1'b1;
    repeat (25) step();
    access_active = 1'b0;
    lp_req = 1'b1;
    lp_deep = 1'b0;
    wait_cmd(3'd1, 3, n);
    chk(n == 1, "R9 refresh before low power", n, 1);
    chk(cke == 1'b1, "R9 cke high at refresh", cke, 1);
    wait_cmd(3'd2, 10, n);
    chk(n == 4, "R9 entry after recovery", n, 4);
    lp_req = 1'b0;
    wait_cmd(3'd1, 10, n);
    chk(n == 5, "R8 self-refresh recovery refresh", n, 5);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_enable();
    t_period(20);
    t_period(7);
    t_access();
    t_disable();
    t_lowpower(1'b0);
    t_lowpower(1'b1);
    t_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule